// File: doc/BRIEF.md
# Speculative Early-Sample Read Controller with Zero-Count Retry

This block sits on the read path of a resistive memory line. It does not wait the full, worst-case sensing time. It samples the sense outputs early and checks the sample against check bits that were stored with the line. The check bits hold the binary count of zero bits in the line data.

Early sampling can only turn a one into a zero, so any early error raises the zero count. Recounting the zeros and comparing the result with the stored value therefore catches every such error, whatever the number of flipped bits. A clean early sample is returned at once. A mismatch causes the same address to be sensed again with the conservative latency, and that second result is returned without a further check, marked as retried.

The write side of the block is a combinational encoder. It produces the zero count for an incoming line, to be stored next to the data. The array itself is outside the block. The controller drives a start pulse, an address and a latency-mode bit. It raises a strobe in the cycle in which it captures the sense data and the check bits.

Top module: `spec_read_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid`, `sense_go` and `sense_strobe` are 0.
- R2: `wr_chk` always equals the number of zero bits in `wr_data`, written as an unsigned binary count of CHK_W bits. An all-zero line gives LINE_W (512) and an all-one line gives 0.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle `sense_go` is 1 for exactly one cycle, with `sense_addr` equal to the accepted `req_addr` and `sense_full` equal to 0.
- R4: `sense_strobe` is 1 for a single cycle. Counting the `sense_go` cycle as cycle 1, this is cycle EARLY_LAT (default 12) for an early sense and cycle FULL_LAT (default 16) for a full sense. The data and check bits are captured only in that cycle.
- R5: When the zero count of the early sample equals the captured check bits, `rsp_valid` pulses for one cycle in cycle EARLY_LAT+2 (counted as in R4). `rsp_data` then carries the early sample and `rsp_retried` is 0.
- R6: When the counts differ, no early response is given. In cycle EARLY_LAT+2 `sense_go` pulses again, with `sense_full` equal to 1 and the same `sense_addr`.
- R7: The full-latency sample is returned unchecked in the cycle after its strobe, with `rsp_retried` equal to 1. This holds even if that sample and its check bits disagree.
- R8: `req_ready` is 0 from the accepting edge until the response cycle. `req_valid` has no effect while `req_ready` is 0.
- R9: `req_ready` is 1 in the cycle in which `rsp_valid` is 1, so a new request can be accepted at the edge that ends that cycle.
- R10: Any early error that clears one or more set bits leads to a retry. A sample whose one-bits are intact is accepted without retry, whatever happens to bits that are already zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Line address of the request |
| req_ready | output | 1 | Controller idle and able to accept |
| sense_go | output | 1 | One-cycle start of a sense operation |
| sense_addr | output | ADDR_W | Line address being sensed |
| sense_full | output | 1 | 0 for an early sense, 1 for a full-latency sense |
| sense_strobe | output | 1 | Capture cycle of the sense data |
| sense_data | input | LINE_W | Sensed line data |
| sense_chk | input | CHK_W | Stored zero count for the line |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | LINE_W | Returned line data |
| rsp_retried | output | 1 | Response came from the full-latency retry |
| wr_data | input | LINE_W | Line being written |
| wr_chk | output | CHK_W | Zero count to store with the written line |

## Verification
Two pairs of functions can fall in the same cycle. A response can coincide with the acceptance of the next request. The write-side encoder can be used while a read is in its check or retry phase, because it shares the zero-counting structure with the read check but not its input.

The bench holds `req_valid` high across many cycles with a changing address, so each response cycle also takes in a new request. During the same stretch it changes `wr_data` every cycle. A behavioural model predicts `req_ready`, `sense_go`, `sense_strobe` and the response on every clock, and the encoder result is compared with an independent zero count after each change.

// File: rtl/sr_pkg.sv
package sr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EARLY = 2'd1,
      ST_CHECK = 2'd2,
      ST_FULL  = 2'd3
   } sr_state_e;
endpackage

// File: rtl/sr_zero_count.sv
// Counts the zero bits of a vector. CHUNK_W = 0 gives one flat loop.
// Otherwise per-chunk partial counts are summed.
module sr_zero_count #(
   parameter int LINE_W  = 512,
   parameter int CNT_W   = 10,
   parameter int CHUNK_W = 8
) (
   input  logic [LINE_W-1:0] bits,
   output logic [CNT_W-1:0]  zeros
);
   if (CNT_W < $clog2(LINE_W + 1)) begin : g_bad_cnt
      $error("sr_zero_count: CNT_W too narrow for LINE_W");
   end

   if (CHUNK_W == 0) begin : g_flat
      always_comb begin
         zeros = '0;
         for (int i = 0; i < LINE_W; i++)
            zeros = zeros + {{(CNT_W-1){1'b0}}, ~bits[i]};
      end
   end else begin : g_chunked
      localparam int NCH    = LINE_W / CHUNK_W;
      localparam int PART_W = $clog2(CHUNK_W + 1);
      if (LINE_W % CHUNK_W != 0) begin : g_bad_chunk
         $error("sr_zero_count: LINE_W must be a multiple of CHUNK_W");
      end
      logic [PART_W-1:0] parts [NCH];
      for (genvar c = 0; c < NCH; c++) begin : g_part
         always_comb begin
            parts[c] = '0;
            for (int j = 0; j < CHUNK_W; j++)
               parts[c] = parts[c] + {{(PART_W-1){1'b0}}, ~bits[c*CHUNK_W + j]};
         end
      end
      always_comb begin
         zeros = '0;
         for (int c = 0; c < NCH; c++)
            zeros = zeros + CNT_W'(parts[c]);
      end
   end
endmodule

// File: rtl/sr_lat_timer.sv
// Counts from the start cycle (cycle 1). It raises strobe in the cycle
// equal to the selected latency.
module sr_lat_timer #(
   parameter int EARLY_LAT = 12,
   parameter int FULL_LAT  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_full,
   output logic strobe
);
   localparam int CNT_W = $clog2(FULL_LAT + 1);
   localparam logic [CNT_W-1:0] E_CNT = CNT_W'(EARLY_LAT);
   localparam logic [CNT_W-1:0] F_CNT = CNT_W'(FULL_LAT);

   logic             run_q;
   logic             full_q;
   logic [CNT_W-1:0] cnt_q;

   assign strobe = run_q && (cnt_q == (full_q ? F_CNT : E_CNT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         full_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         run_q  <= 1'b1;
         full_q <= start_full;
         cnt_q  <= CNT_W'(1);
      end else if (strobe) begin
         run_q  <= 1'b0;
      end else if (run_q) begin
         cnt_q  <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/spec_read_ctrl.sv
module spec_read_ctrl
   import sr_pkg::*;
#(
   parameter int LINE_W    = 512,
   parameter int ADDR_W    = 16,
   parameter int EARLY_LAT = 12,
   parameter int FULL_LAT  = 16,
   parameter int CHUNK_W   = 8,
   parameter int CHK_W     = $clog2(LINE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              sense_go,
   output logic [ADDR_W-1:0] sense_addr,
   output logic              sense_full,
   output logic              sense_strobe,
   input  logic [LINE_W-1:0] sense_data,
   input  logic [CHK_W-1:0]  sense_chk,
   output logic              rsp_valid,
   output logic [LINE_W-1:0] rsp_data,
   output logic              rsp_retried,
   input  logic [LINE_W-1:0] wr_data,
   output logic [CHK_W-1:0]  wr_chk
);
   if (EARLY_LAT < 1) begin : g_bad_early
      $error("spec_read_ctrl: EARLY_LAT must be at least 1");
   end
   if (EARLY_LAT >= FULL_LAT) begin : g_bad_order
      $error("spec_read_ctrl: EARLY_LAT must be below FULL_LAT");
   end
   if (CHK_W < $clog2(LINE_W + 1)) begin : g_bad_chk
      $error("spec_read_ctrl: CHK_W cannot hold a full zero count");
   end

   sr_state_e         state_q;
   logic [LINE_W-1:0] data_q;
   logic [CHK_W-1:0]  chk_q;
   logic [ADDR_W-1:0] addr_q;
   logic              go_q;
   logic              full_q;
   logic              rsp_v_q;
   logic [LINE_W-1:0] rsp_d_q;
   logic              rsp_r_q;
   logic [CHK_W-1:0]  rd_zeros;
   logic              accept;
   logic              retry;
   logic              strobe;

   // Write side: encoder for the stored check bits.
   sr_zero_count #(.LINE_W(LINE_W), .CNT_W(CHK_W), .CHUNK_W(CHUNK_W)) u_wr_enc (
      .bits  (wr_data),
      .zeros (wr_chk)
   );

   // Read side: recount of the captured early sample.
   sr_zero_count #(.LINE_W(LINE_W), .CNT_W(CHK_W), .CHUNK_W(CHUNK_W)) u_rd_cnt (
      .bits  (data_q),
      .zeros (rd_zeros)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign retry     = (state_q == ST_CHECK) && (rd_zeros != chk_q);

   sr_lat_timer #(.EARLY_LAT(EARLY_LAT), .FULL_LAT(FULL_LAT)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept || retry),
      .start_full (retry),
      .strobe     (strobe)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         data_q  <= '0;
         chk_q   <= '0;
         addr_q  <= '0;
         go_q    <= 1'b0;
         full_q  <= 1'b0;
         rsp_v_q <= 1'b0;
         rsp_d_q <= '0;
         rsp_r_q <= 1'b0;
      end else begin
         go_q    <= 1'b0;
         rsp_v_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  go_q    <= 1'b1;
                  full_q  <= 1'b0;
                  state_q <= ST_EARLY;
               end
            end
            ST_EARLY: begin
               if (strobe) begin
                  data_q  <= sense_data;
                  chk_q   <= sense_chk;
                  state_q <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (retry) begin
                  go_q    <= 1'b1;
                  full_q  <= 1'b1;
                  state_q <= ST_FULL;
               end else begin
                  rsp_v_q <= 1'b1;
                  rsp_d_q <= data_q;
                  rsp_r_q <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            ST_FULL: begin
               if (strobe) begin
                  rsp_v_q <= 1'b1;
                  rsp_d_q <= sense_data;
                  rsp_r_q <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sense_go     = go_q;
   assign sense_addr   = addr_q;
   assign sense_full   = full_q;
   assign sense_strobe = strobe;
   assign rsp_valid    = rsp_v_q;
   assign rsp_data     = rsp_d_q;
   assign rsp_retried  = rsp_r_q;
endmodule

// File: rtl/sr_ctrl_checker.sv
module sr_ctrl_checker #(
   parameter int LINE_W    = 512,
   parameter int ADDR_W    = 16,
   parameter int EARLY_LAT = 12,
   parameter int FULL_LAT  = 16,
   parameter int CHK_W     = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_ready,
   input logic              sense_go,
   input logic [ADDR_W-1:0] sense_addr,
   input logic              sense_full,
   input logic              sense_strobe,
   input logic              rsp_valid,
   input logic              rsp_retried,
   input logic [LINE_W-1:0] wr_data,
   input logic [CHK_W-1:0]  wr_chk
);
   localparam int CW = $clog2(FULL_LAT + 2);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   // Cycle position since the most recent sense_go (sense_go cycle = 1).
   logic [CW-1:0] since_q;
   logic [CW-1:0] since_now;
   assign since_now = sense_go ? CW'(1) : since_q;

   always_ff @(posedge clk) begin
      if (!rst_n) since_q <= CMAX;
      else        since_q <= (since_now == CMAX) ? CMAX : since_now + CW'(1);
   end

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (req_ready && !rsp_valid && !sense_go));

   p_all_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data == {LINE_W{1'b1}}) |-> (wr_chk == '0));

   p_accept_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (sense_go && !sense_full && sense_addr == $past(req_addr)));

   p_strobe_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sense_strobe |-> (since_now == (sense_full ? CW'(FULL_LAT) : CW'(EARLY_LAT))));

   p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_clean_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_retried) |-> ($past(sense_strobe, 2) && !$past(sense_full, 2)));

   p_retry_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_go && sense_full) |-> ($past(sense_strobe, 2) && !$past(sense_full, 2)
                                    && $stable(sense_addr)));

   p_retry_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_retried) |-> ($past(sense_strobe) && $past(sense_full)));

   p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_go || sense_strobe) |-> !req_ready);

   p_ready_at_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);
endmodule

bind spec_read_ctrl sr_ctrl_checker #(
   .LINE_W(LINE_W), .ADDR_W(ADDR_W), .EARLY_LAT(EARLY_LAT),
   .FULL_LAT(FULL_LAT), .CHK_W(CHK_W)
) u_sr_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .req_ready(req_ready), .sense_go(sense_go), .sense_addr(sense_addr),
   .sense_full(sense_full), .sense_strobe(sense_strobe), .rsp_valid(rsp_valid),
   .rsp_retried(rsp_retried), .wr_data(wr_data), .wr_chk(wr_chk)
);

// File: tb/spec_read_ctrl_test.sv
module spec_read_ctrl_test;
   localparam int LW = 512;
   localparam int AW = 16;
   localparam int EL = 12;
   localparam int FL = 16;
   localparam int CW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_ready;
   logic          sense_go;
   logic [AW-1:0] sense_addr;
   logic          sense_full;
   logic          sense_strobe;
   logic [LW-1:0] sense_data;
   logic [CW-1:0] sense_chk;
   logic          rsp_valid;
   logic [LW-1:0] rsp_data;
   logic          rsp_retried;
   logic [LW-1:0] wr_data = '1;
   logic [CW-1:0] wr_chk;

   always #5 clk = ~clk;

   spec_read_ctrl #(.LINE_W(LW), .ADDR_W(AW), .EARLY_LAT(EL), .FULL_LAT(FL)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .sense_go(sense_go), .sense_addr(sense_addr),
      .sense_full(sense_full), .sense_strobe(sense_strobe), .sense_data(sense_data),
      .sense_chk(sense_chk), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_retried(rsp_retried), .wr_data(wr_data), .wr_chk(wr_chk)
   );

   int checks = 0;
   int failures = 0;

   logic [LW-1:0] mem [8];
   logic [CW-1:0] chk_mem [8];
   logic [LW-1:0] early_mask = '0;
   logic [LW-1:0] full_mask = '0;

   function automatic int zcount(logic [LW-1:0] v);
      int n = 0;
      for (int i = 0; i < LW; i++) if (v[i] == 1'b0) n++;
      return n;
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [LW-1:0] act, input logic [LW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Array model: correct data only in the capture cycle. The early sense
   // clears the bits of early_mask and the full sense those of full_mask.
   logic [LW-1:0] good_line;
   always_comb begin
      good_line  = mem[sense_addr[2:0]] & ~(sense_full ? full_mask : early_mask);
      sense_data = sense_strobe ? good_line : ~good_line;
      sense_chk  = chk_mem[sense_addr[2:0]];
   end

   // Behavioural reference model, advanced on each rising edge.
   bit            m_busy = 0, m_rsp = 0, m_go = 0, m_full = 0, m_retry = 0, m_rsp_ret = 0;
   bit            was_idle;
   int            m_left = 0;
   logic [AW-1:0] m_addr = '0;
   logic [LW-1:0] m_data = '0, m_rsp_data = '0, line_v;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_rsp = 0; m_go = 0; m_full = 0; m_left = 0;
      end else begin
         was_idle = !m_busy;
         m_rsp = 0;
         m_go  = 0;
         if (m_busy) begin
            m_left--;
            if (m_retry && m_left == FL) begin m_go = 1; m_full = 1; end
            if (m_left == 0) begin
               m_busy = 0; m_rsp = 1; m_rsp_data = m_data; m_rsp_ret = m_retry;
            end
         end
         if (was_idle && req_valid) begin
            m_busy  = 1; m_go = 1; m_full = 0; m_addr = req_addr;
            line_v  = mem[req_addr[2:0]];
            m_retry = |(line_v & early_mask);
            m_left  = m_retry ? EL + 1 + FL : EL + 1;
            m_data  = m_retry ? (line_v & ~full_mask) : line_v;
         end
      end
   end

   // Comparison away from the active edge.
   bit exp_strobe;
   always @(negedge clk) begin
      if (rst_n) begin
         exp_strobe = m_busy && (m_left == (m_retry ? FL + 2 : 2) || (m_retry && m_left == 1));
         check(req_ready == !m_busy, "R8 req_ready", LW'(req_ready), LW'(!m_busy));
         check(sense_go == m_go, "R3/R6 sense_go", LW'(sense_go), LW'(m_go));
         if (m_go) begin
            check(sense_addr == m_addr, "R3/R6 sense_addr", LW'(sense_addr), LW'(m_addr));
            check(sense_full == m_full, "R6 sense_full", LW'(sense_full), LW'(m_full));
         end
         check(sense_strobe == exp_strobe, "R4 sense_strobe", LW'(sense_strobe), LW'(exp_strobe));
         check(rsp_valid == m_rsp, "R5/R7 rsp_valid", LW'(rsp_valid), LW'(m_rsp));
         if (m_rsp) begin
            check(rsp_data == m_rsp_data, "R5/R7 rsp_data", rsp_data, m_rsp_data);
            check(rsp_retried == m_rsp_ret, "R7 rsp_retried", LW'(rsp_retried), LW'(m_rsp_ret));
            check(req_ready == 1'b1, "R9 ready at response", LW'(req_ready), LW'(1));
         end
      end
   end

   task automatic encode_check(input logic [LW-1:0] v, input string tag);
      wr_data = v;
      #1;
      check(int'(wr_chk) == zcount(v), tag, LW'(wr_chk), LW'(zcount(v)));
   endtask

   task automatic do_read(input int a);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_addr  = AW'(a);
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = 16'hBEEF;
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      for (int i = 0; i < 8; i++) begin mem[i] = '0; chk_mem[i] = '0; end
      repeat (3) @(negedge clk);
      // R1: values during and right after reset
      check(req_ready && !rsp_valid && !sense_go && !sense_strobe, "R1 reset outputs",
            LW'({req_ready, rsp_valid, sense_go, sense_strobe}), LW'(4'b1000));
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid && !sense_go, "R1 after release",
            LW'({req_ready, rsp_valid, sense_go}), LW'(3'b100));

      // R2: write-side encoding of the lines, corners included
      encode_check('0, "R2 all zeros gives 512");
      check(wr_chk == CW'(512), "R2 count 512", LW'(wr_chk), LW'(512));
      encode_check('1, "R2 all ones gives 0");
      for (int i = 0; i < 8; i++) begin
         case (i)
            0: mem[i] = '0;
            1: mem[i] = '1;
            2: mem[i] = {16{32'hA5C3_0F71}};
            3: mem[i] = {16{32'h0000_0001}};
            default: mem[i] = {16{32'h9E37_79B9 * (i + 1)}} ^ {8{64'(i * 7919)}};
         endcase
         encode_check(mem[i], "R2 line encode");
         chk_mem[i] = CW'(zcount(mem[i]));
      end

      // R5: clean early reads
      early_mask = '0; full_mask = '0;
      do_read(2);
      do_read(1);
      // R10: early mask only on zero bits of the line -> no retry
      early_mask = ~mem[2];
      do_read(2);
      early_mask = '1;
      do_read(0);
      // R6/R10: a single cleared one-bit forces a retry
      early_mask = '0; early_mask[0] = 1'b1;
      do_read(3);
      // R10: many cleared bits
      early_mask = {16{32'hFFFF_0000}};
      do_read(1);
      do_read(5);
      // R7: full result corrupted too; returned unchecked and marked retried
      full_mask = '0; full_mask[100] = 1'b1; full_mask[7] = 1'b1;
      do_read(1);
      full_mask = '0;

      // R8/R9 with concurrent writes: req_valid held with a moving address
      for (int k = 0; k < 200; k++) begin
         req_valid  = 1'b1;
         req_addr   = AW'((k * 3) % 8);
         early_mask = (k % 3 == 0) ? {16{32'h0000_8001}} : '0;
         encode_check({16{32'h1357_9BDF}} ^ {8{64'(k * 1021)}}, "R2 encode during reads");
         @(negedge clk);
      end
      req_valid = 1'b0;
      while (m_busy) @(negedge clk);
      repeat (3) @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule